// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a serial PCM audio line into a stream of parallel samples. It watches a bit clock, a frame clock and one data line, each oversampled and synchronized into a faster system clock. It understands four framings. Three are two-channel framings (I2S, left-justified and right-justified). The fourth is a time-division-multiplexed framing that carries 4, 6 or 8 channels per frame. The word length is selectable as 16, 20, 24 or 32 bits. Each recovered word is sign-extended to 32 bits and handed out with its channel number.

The output is a valid/ready stream with a single holding register. Once `out_valid` is raised, the word and its channel stay frozen until `out_ready` is seen high at a clock edge. The audio line cannot be stalled. A sample that completes while the holding register is still occupied is therefore dropped, and `overrun` pulses for one cycle. The holding register is not disturbed. The configuration inputs are only changed while `enable` is low. A frame clock edge that comes too early discards the half-finished word and sets a sticky `frame_err`.

Top module: `audio_serial_rx`

## Requirements
- R1: With `fmt_sel`=1 (left-justified), the bit sampled on the first bit-clock rising edge after a frame clock change is the MSB. The word fills the next W bits. Frame clock high marks channel 0 and low marks channel 1.
- R2: With `fmt_sel`=0 (I2S), the MSB is the bit one bit-clock later than in R1. Frame clock low marks channel 0 and high marks channel 1. Each half-frame must hold at least W+1 bits.
- R3: With `fmt_sel`=2 (right-justified), the word is the last W bits before a frame clock change, and it is delivered after that change. Frame clock high marks channel 0.
- R4: With `fmt_sel`=3 (TDM), a rising frame clock marks slot 0, and the bit sampled with it is the slot's first bit. Slots are 32 bit clocks each, with the word in the first W bits. `tdm_sel` 0/1/2/3 selects 4/6/8/8 channels, numbered 0 upward. Bits past the last channel's slot are ignored.
- R5: `wlen_sel` 0/1/2/3 selects W = 16/20/24/32. Bits of a slot or half-frame outside the word are ignored, and `out_data` is the word sign-extended to 32 bits.
- R6: After `enable` rises, the first sampled bit only records the frame clock level. No sample is produced until a frame clock edge has been seen after that.
- R7: A frame clock edge that arrives before the word is complete produces no sample for that half-frame. In two-channel modes this means before W bits (W+1 in I2S). In TDM it means before all channel slots have passed. The same edge sets `frame_err`, which stays high until `enable` falls.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold. A sample arriving then is dropped, and `overrun` pulses high for one cycle.
- R9: After reset, or while `enable` is low, `out_valid`, `overrun` and `frame_err` are low.
- R10: `bclk`, `lrclk` and `sdata` are asynchronous and are synchronized into `clk`. Each bit-clock phase must last at least 3 `clk` cycles. `lrclk` and `sdata` change only while `bclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the audio clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; low clears lock, stream and error |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| wlen_sel | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| tdm_sel | input | 2 | TDM channel count: 0=4, 1=6, 2/3=8 |
| bclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| lrclk | input | 1 | Frame clock or TDM frame sync |
| sdata | input | 1 | Serial data line |
| out_data | output | 32 | Sign-extended sample |
| out_chan | output | 3 | Channel number of the sample |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| overrun | output | 1 | One-cycle pulse when a sample is dropped |
| frame_err | output | 1 | Sticky early-frame-edge flag |

## Verification
A wrong bit counter or misplaced word window shows up at the ports as a shifted or wrongly masked word. It appears in the very first sample after lock, less than one half-frame after the locking edge. A wrong slot counter or channel decode shows up as a wrong `out_chan`, or as missing or extra samples, within one TDM frame. A lock or error bookkeeping fault either raises `frame_err` on well-formed frames or misses it on a shortened half-frame. In both cases it is visible at the next frame clock edge. A fault in the holding register shows up during a stall as a changed word or a missing `overrun` pulse.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int SMP_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [3:0] slot_count(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [SMP_W-1:0] widen(input logic [SMP_W-1:0] raw, input logic [1:0] code);
    case (code)
      2'd0:    return {{16{raw[15]}}, raw[15:0]};
      2'd1:    return {{12{raw[19]}}, raw[19:0]};
      2'd2:    return {{8{raw[23]}}, raw[23:0]};
      default: return raw;
    endcase
  endfunction
endpackage

// File: rtl/asr_front.sv
module asr_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdata,
  output logic bit_stb,
  output logic bit_lr,
  output logic bit_sd
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] b_q, l_q, d_q;
  logic              b_last;

  // synchronizer chains, equal depth so the three lines stay aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q    <= '0;
      l_q    <= '0;
      d_q    <= '0;
      b_last <= 1'b0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        b_q[i] <= b_q[i-1];
        l_q[i] <= l_q[i-1];
        d_q[i] <= d_q[i-1];
      end
      b_q[0] <= bclk;
      l_q[0] <= lrclk;
      d_q[0] <= sdata;
      b_last <= b_q[LAST];
    end
  end

  assign bit_stb = b_q[LAST] & ~b_last;
  assign bit_lr  = l_q[LAST];
  assign bit_sd  = d_q[LAST];

  // R10: a synchronized rising edge is a single-cycle event
  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/asr_deser.sv
module asr_deser
  import asr_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int SLOT_W = 4,
  parameter int CH_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       wlen_sel,
  input  logic [1:0]       tdm_sel,
  input  logic             bit_stb,
  input  logic             bit_lr,
  input  logic             bit_sd,
  output logic             smp_valid,
  output logic [SMP_W-1:0] smp_data,
  output logic [CH_W-1:0]  smp_ch,
  output logic             frame_err
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(31);

  fmt_e              fmt;
  logic [CNT_W-1:0]  wlen, need, bitcnt;
  logic [SLOT_W-1:0] nslots, slot;
  logic [SMP_W-1:0]  shreg, shreg_nx;
  logic              primed, locked, lr_prev;
  logic              is_tdm, frm_edge, short_frame, word_done;
  logic [CH_W-1:0]   ch_now;

  always_comb begin
    fmt      = fmt_e'(fmt_sel);
    wlen     = CNT_W'(word_bits(wlen_sel));
    nslots   = SLOT_W'(slot_count(tdm_sel));
    is_tdm   = (fmt == FMT_TDM);
    need     = (fmt == FMT_I2S) ? wlen + CNT_W'(1) : wlen;
    shreg_nx = {shreg[SMP_W-2:0], bit_sd};
    frm_edge = primed && (is_tdm ? (bit_lr & ~lr_prev) : (bit_lr ^ lr_prev));
    short_frame = locked && (is_tdm ? (slot < nslots) : (bitcnt < need));
    case (fmt)
      FMT_LJ:  word_done = (bitcnt == wlen - CNT_W'(1));
      FMT_I2S: word_done = (bitcnt == wlen);
      FMT_TDM: word_done = (slot < nslots) && (bitcnt == wlen - CNT_W'(1));
      default: word_done = 1'b0;
    endcase
    case (fmt)
      FMT_LJ:  ch_now = bit_lr ? CH_W'(0) : CH_W'(1);
      FMT_I2S: ch_now = bit_lr ? CH_W'(1) : CH_W'(0);
      default: ch_now = CH_W'(slot);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      locked    <= 1'b0;
      lr_prev   <= 1'b0;
      bitcnt    <= '0;
      slot      <= '0;
      shreg     <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_ch    <= '0;
      frame_err <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (!enable) begin
        primed    <= 1'b0;
        locked    <= 1'b0;
        frame_err <= 1'b0;
      end else if (bit_stb) begin
        lr_prev <= bit_lr;
        if (!primed) begin
          primed <= 1'b1;
        end else begin
          shreg <= shreg_nx;
          if (frm_edge) begin
            locked <= 1'b1;
            bitcnt <= CNT_W'(1);
            slot   <= '0;
            if (short_frame) frame_err <= 1'b1;
            if (locked && !short_frame && fmt == FMT_RJ) begin
              smp_valid <= 1'b1;
              smp_data  <= widen(shreg, wlen_sel);
              smp_ch    <= lr_prev ? CH_W'(0) : CH_W'(1);
            end
          end else if (locked) begin
            if (is_tdm && bitcnt == SLOT_END) begin
              bitcnt <= '0;
              if (slot < nslots) slot <= slot + SLOT_W'(1);
            end else if (bitcnt != CNT_MAX) begin
              bitcnt <= bitcnt + CNT_W'(1);
            end
            if (word_done) begin
              smp_valid <= 1'b1;
              smp_data  <= widen(shreg_nx, wlen_sel);
              smp_ch    <= ch_now;
            end
          end
        end
      end
    end
  end

  // R4: channel numbers stay inside the configured frame
  assert_chan_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (int'(smp_ch) < (is_tdm ? int'(nslots) : 2)));

  // R7: the error flag only clears through enable
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && enable) |=> frame_err);

  // R6: no word leaves before a frame edge has locked the counter
  assert_no_word_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !primed) |=> !smp_valid);
endmodule

// File: rtl/asr_ostage.sv
module asr_ostage
  import asr_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_data,
  input  logic [CH_W-1:0]  in_ch,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_data,
  output logic [CH_W-1:0]  out_chan,
  output logic             overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
      overrun   <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (!enable) begin
        out_valid <= 1'b0;
      end else if (in_valid && (!out_valid || out_ready)) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_chan  <= in_ch;
      end else if (in_valid) begin
        overrun <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8: a stalled word is frozen until taken
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6,
  parameter int SLOT_W      = 4,
  parameter int CH_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       wlen_sel,
  input  logic [1:0]       tdm_sel,
  input  logic             bclk,
  input  logic             lrclk,
  input  logic             sdata,
  output logic [SMP_W-1:0] out_data,
  output logic [CH_W-1:0]  out_chan,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             overrun,
  output logic             frame_err
);
  logic             stb, s_lr, s_sd, w_valid;
  logic [SMP_W-1:0] w_data;
  logic [CH_W-1:0]  w_ch;

  asr_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .bit_stb(stb), .bit_lr(s_lr), .bit_sd(s_sd)
  );

  asr_deser #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .CH_W(CH_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .tdm_sel(tdm_sel),
    .bit_stb(stb), .bit_lr(s_lr), .bit_sd(s_sd),
    .smp_valid(w_valid), .smp_data(w_data), .smp_ch(w_ch), .frame_err(frame_err)
  );

  asr_ostage #(.CH_W(CH_W)) u_out (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_valid(w_valid), .in_data(w_data), .in_ch(w_ch), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan), .overrun(overrun)
  );

  // R5: 16-bit words leave with their upper half copied from bit 15
  assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && out_valid && wlen_sel == 2'd0) |->
      (out_data[31:15] == 17'h0 || out_data[31:15] == 17'h1FFFF));

  // R9: nothing is offered while disabled
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_valid && !frame_err));
endmodule

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;
  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0]  fmt_sel = 2'd1, wlen_sel = 2'd0, tdm_sel = 2'd0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0, out_ready = 1'b1;
  logic [31:0] out_data;
  logic [2:0]  out_chan;
  logic        out_valid, overrun, frame_err;

  audio_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .tdm_sel(tdm_sel), .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .out_data(out_data),
    .out_chan(out_chan), .out_valid(out_valid), .out_ready(out_ready), .overrun(overrun),
    .frame_err(frame_err)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  wl;
    logic [1:0]  tdm;
    logic [5:0]  half;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  // fmt: 0 I2S, 1 LJ, 2 RJ, 3 TDM (a = slot base value)
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 2'd0, 6'd32, 32'h0000_8001, 32'h0000_1234},
    '{2'd1, 2'd2, 2'd0, 6'd32, 32'h0080_0000, 32'h007F_FFFF},
    '{2'd0, 2'd0, 2'd0, 6'd32, 32'h0000_7ABC, 32'h0000_C001},
    '{2'd0, 2'd1, 2'd0, 6'd32, 32'h0008_0001, 32'h0001_2345},
    '{2'd2, 2'd2, 2'd0, 6'd32, 32'h00AB_CDEF, 32'h0001_2345},
    '{2'd2, 2'd0, 2'd0, 6'd32, 32'h0000_FFFF, 32'h0000_0001},
    '{2'd1, 2'd3, 2'd0, 6'd32, 32'h8000_0000, 32'h7FFF_FFFF},
    '{2'd0, 2'd2, 2'd0, 6'd32, 32'h00F0_0F0F, 32'h0000_F0F1},
    '{2'd3, 2'd2, 2'd0, 6'd32, 32'h00A5_A5A5, 32'h0},
    '{2'd3, 2'd0, 2'd1, 6'd32, 32'h0000_8421, 32'h0},
    '{2'd3, 2'd3, 2'd2, 6'd32, 32'hDEAD_BEEF, 32'h0},
    '{2'd2, 2'd1, 2'd0, 6'd24, 32'h0008_0000, 32'h0007_FFFF}
  };

  int checks = 0, fails = 0, wr = 0, rd = 0, ovr_cnt = 0;
  logic [31:0] exp_d [256];
  logic [2:0]  exp_c [256];
  string tag = "R9";
  bit done = 1'b0;

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : (c == 2'd2) ? 24 : 32;
  endfunction

  function automatic logic [31:0] sx(input logic [31:0] s, input int w);
    logic [31:0] m, v;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    v = s & m;
    if (w < 32 && v[w-1]) v = v | ~m;
    return v;
  endfunction

  function automatic logic fbit(input int fmt, input int w, input logic [31:0] s, input int b, input int half);
    if (fmt == 1) return (b < w) ? s[w-1-b] : 1'b1;
    if (fmt == 0) return (b >= 1 && b <= w) ? s[w-b] : 1'b1;
    return (b >= half - w) ? s[half-1-b] : 1'b1;
  endfunction

  function automatic logic [31:0] tslot(input logic [31:0] base, input int k);
    return base + 32'h0103_0507 * k;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push(input logic [31:0] d, input logic [2:0] c);
    exp_d[wr] = d; exp_c[wr] = c; wr++;
  endtask

  task automatic bit_out(input logic l, input logic d);
    lrclk = l; sdata = d;
    repeat (4) @(posedge clk); #1; bclk = 1'b1;
    repeat (4) @(posedge clk); #1; bclk = 1'b0;
  endtask

  task automatic setup(input logic [1:0] f, input logic [1:0] w, input logic [1:0] t);
    enable = 1'b0;
    repeat (3) @(posedge clk); #1;
    fmt_sel = f; wlen_sel = w; tdm_sel = t;
    enable = 1'b1;
    @(posedge clk); #1;
  endtask

  // stream monitor: every accepted word is compared in order
  always @(negedge clk) begin
    if (rst_n && overrun) ovr_cnt++;
    if (rst_n && out_valid && out_ready) begin
      if (rd >= wr) check(1'b0, {tag, " unexpected word"}, out_data, 32'h0);
      else begin
        check(out_data == exp_d[rd], {tag, " R5 data"}, out_data, exp_d[rd]);
        check(out_chan == exp_c[rd], {tag, " channel"}, 32'(out_chan), 32'(exp_c[rd]));
      end
      rd++;
    end
  end

  task automatic run_vec(input vec_t v);
    int w, half, n, fbits;
    logic lft;
    w = wbits(v.wl); half = int'(v.half);
    setup(v.fmt, v.wl, v.tdm);
    if (v.fmt == 2'd3) begin
      tag = "R4";
      n = (v.tdm == 2'd0) ? 4 : (v.tdm == 2'd1) ? 6 : 8;
      fbits = (n == 4) ? 192 : n * 32;   // N=4 frames carry two unused slots
      for (int fr = 0; fr < 2; fr++)
        for (int k = 0; k < n; k++) push(sx(tslot(v.a, k), w), 3'(k));
      bit_out(1'b0, 1'b0); bit_out(1'b0, 1'b0);
      for (int fr = 0; fr < 2; fr++)
        for (int b = 0; b < fbits; b++) begin
          logic [31:0] s;
          s = tslot(v.a, b / 32);
          bit_out(b == 0, ((b / 32) < n && (b % 32) < w) ? s[w-1-(b%32)] : 1'b1);
        end
    end else begin
      tag = (v.fmt == 2'd0) ? "R2" : (v.fmt == 2'd1) ? "R1" : "R3";
      lft = (v.fmt == 2'd0) ? 1'b0 : 1'b1;
      for (int fr = 0; fr < 2; fr++) begin
        push(sx(v.a, w), 3'd0);
        push(sx(v.b, w), 3'd1);
      end
      bit_out(~lft, 1'b0); bit_out(~lft, 1'b0);
      for (int fr = 0; fr < 2; fr++)
        for (int h = 0; h < 2; h++)
          for (int b = 0; b < half; b++)
            bit_out(h == 0 ? lft : ~lft, fbit(int'(v.fmt), w, h == 0 ? v.a : v.b, b, half));
      bit_out(lft, 1'b0); bit_out(lft, 1'b0);
    end
    repeat (20) @(posedge clk); #1;
    check(rd == wr, {tag, " R10 word count"}, 32'(rd), 32'(wr));
    check(frame_err == 1'b0, {tag, " R7 no false error"}, 32'(frame_err), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    // R9 reset state
    check(out_valid == 1'b0, "R9 out_valid in reset", 32'(out_valid), 32'h0);
    check(frame_err == 1'b0, "R9 frame_err in reset", 32'(frame_err), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    check(overrun == 1'b0, "R9 overrun after reset", 32'(overrun), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6: data with a steady frame clock yields nothing
    tag = "R6";
    setup(2'd1, 2'd0, 2'd0);
    for (int b = 0; b < 40; b++) bit_out(1'b1, 1'b1);
    repeat (10) @(posedge clk); #1;
    check(rd == wr && !out_valid, "R6 no word before lock", 32'(rd), 32'(wr));

    // R7: short left half in left-justified mode
    tag = "R7";
    setup(2'd1, 2'd2, 2'd0);
    push(sx(32'h0012_3456, 24), 3'd1);
    bit_out(1'b0, 1'b0); bit_out(1'b0, 1'b0);
    for (int b = 0; b < 10; b++) bit_out(1'b1, 1'b1);
    for (int b = 0; b < 32; b++) bit_out(1'b0, fbit(1, 24, 32'h0012_3456, b, 32));
    bit_out(1'b1, 1'b0); bit_out(1'b1, 1'b0);
    repeat (20) @(posedge clk); #1;
    check(rd == wr, "R7 partial half discarded", 32'(rd), 32'(wr));
    check(frame_err == 1'b1, "R7 error raised", 32'(frame_err), 32'h1);
    enable = 1'b0;
    repeat (3) @(posedge clk); #1;
    check(frame_err == 1'b0, "R9 error cleared by disable", 32'(frame_err), 32'h0);

    // R7: TDM frame sync after two of four slots
    setup(2'd3, 2'd0, 2'd0);
    for (int k = 0; k < 2; k++) push(sx(tslot(32'h0000_4C3B, k), 16), 3'(k));
    for (int k = 0; k < 4; k++) push(sx(tslot(32'h0000_4C3B, k), 16), 3'(k));
    bit_out(1'b0, 1'b0); bit_out(1'b0, 1'b0);
    for (int b = 0; b < 64; b++)
      bit_out(b == 0, (b % 32) < 16 ? tslot(32'h0000_4C3B, b / 32) >> (15 - b % 32) : 1'b0);
    for (int b = 0; b < 128; b++)
      bit_out(b == 0, (b % 32) < 16 ? tslot(32'h0000_4C3B, b / 32) >> (15 - b % 32) : 1'b0);
    repeat (20) @(posedge clk); #1;
    check(rd == wr, "R7 TDM word count", 32'(rd), 32'(wr));
    check(frame_err == 1'b1, "R7 TDM short frame flagged", 32'(frame_err), 32'h1);

    // R8: stalled consumer, second word dropped
    tag = "R8";
    setup(2'd1, 2'd0, 2'd0);
    out_ready = 1'b0;
    ovr_cnt = 0;
    push(sx(32'h0000_9ABC, 16), 3'd0);
    bit_out(1'b0, 1'b0); bit_out(1'b0, 1'b0);
    for (int h = 0; h < 2; h++)
      for (int b = 0; b < 32; b++)
        bit_out(h == 0, fbit(1, 16, h == 0 ? 32'h0000_9ABC : 32'h0000_0123, b, 32));
    bit_out(1'b1, 1'b0);
    repeat (10) @(posedge clk); #1;
    check(out_valid == 1'b1, "R8 word held", 32'(out_valid), 32'h1);
    check(out_data == 32'hFFFF_9ABC, "R8 held data stable", out_data, 32'hFFFF_9ABC);
    check(ovr_cnt == 1, "R8 overrun pulse", 32'(ovr_cnt), 32'h1);
    out_ready = 1'b1;
    repeat (5) @(posedge clk); #1;
    check(rd == wr && !out_valid, "R8 drained after ready", 32'(rd), 32'(wr));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule